// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the eight synchronized pad inputs of one I/O port before they reach the input and interrupt logic. Every pin can be filtered or passed straight through, chosen by its own enable bit. A filtered pin moves its output to a new level only after the raw input has held that level without interruption for a programmed number of millisecond ticks. A bounce back to the old level throws away the partial count.

All pins of the port share one 8-bit count register, in milliseconds, so the longest debounce time is 255 ms. A count of zero turns filtering off for the whole port. The enable bits are written through a masked-write register. The upper half of the data word selects which pins the write touches, and the lower half gives their new enable values. Several drivers can then change their own pins without a read-modify-write. The time base is an external one-cycle `tick_ms` pulse. Register writes are plain single-cycle strobes.

Top module: `port_debounce`

## Requirements
- R1: After reset the count register and all enable bits are 0, every internal filtered level is 0, and every pin's counter is idle.
- R2: A write to offset 0x0 loads `wr_data[7:0]` into the shared count register.
- R3: A write to offset 0x4 updates the enable of pin n to `wr_data[n]` only where `wr_data[8+n]` is 1. Pins whose mask bit is 0 keep their enable.
- R4: A pin whose enable bit is 0 drives `pin_filt[n]` equal to `pad_sync[n]` in the same cycle.
- R5: While the count register is 0, every pin passes `pad_sync[n]` straight through, whatever its enable bit.
- R6: An enabled pin with a nonzero count changes `pin_filt[n]` only after its input has differed from the output for one load cycle, followed by exactly count tick pulses. It never changes in a cycle that does not follow a tick.
- R7: If the input of a counting pin returns to the current output level before the count expires, the partial count is discarded, and a later change needs the full count again.
- R8: A pin loads the count when it starts counting. Rewriting the count register does not alter a count already in progress; it applies from the next start.
- R9: Each pin keeps its own counter, so pins that start at different times switch at different ticks.
- R10: The maximum count, 255, delays the output by 255 ticks.
- R11: A write to any offset other than 0x0 and 0x4 changes neither the count nor any enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse, once per millisecond |
| pad_sync | input | 8 | Synchronized pad levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 16 | Write data: count in [7:0], or mask in [15:8] and value in [7:0] |
| pin_filt | output | 8 | Debounced or bypassed pin levels |

## Verification
The bench checks that a pin does not switch on the tick before the last one, which catches an off-by-one counter. It then bounces a pin partway through its count and checks that the full count is needed again. A design that kept the partial count would switch early.

It rewrites the count while a pin is counting and checks that the pin still uses the old value. A design that read the live count would switch one tick too soon. It also checks masked writes that must leave unselected enables alone, writes to unused offsets, and the 255-tick limit. A wrong mask decode or a truncated counter would show up there as a pin that bypasses or switches at the wrong tick.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned DBC_OFS_COUNT  = 0;
  localparam int unsigned DBC_OFS_ENABLE = 4;

  typedef enum logic {
    DBC_IDLE = 1'b0,
    DBC_WAIT = 1'b1
  } dbc_state_e;
endpackage

// File: rtl/dbc_regs.sv
module dbc_regs
  import dbc_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [2*NPINS-1:0]   wr_data,
  output logic [NPINS-1:0]     en_o,
  output logic [CNT_W-1:0]     cnt_o
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(DBC_OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(DBC_OFS_ENABLE);

  logic [NPINS-1:0] sel_mask;
  logic [NPINS-1:0] sel_val;

  assign sel_mask = wr_data[2*NPINS-1:NPINS];
  assign sel_val  = wr_data[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      en_o  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_COUNT)
        cnt_o <= wr_data[CNT_W-1:0];
      if (wr_addr == A_ENABLE)
        en_o <= (en_o & ~sel_mask) | (sel_val & sel_mask);
    end
  end
endmodule

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter
  import dbc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             pin_o
);
  dbc_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic             level_q;
  logic             bypass;

  assign bypass = !en_i || (cnt_i == '0);
  assign pin_o  = bypass ? raw_i : level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DBC_IDLE;
      left_q  <= '0;
      level_q <= 1'b0;
    end else if (bypass) begin
      // track the pad so enabling filtering later causes no jump
      state_q <= DBC_IDLE;
      level_q <= raw_i;
    end else if (raw_i == level_q) begin
      state_q <= DBC_IDLE;
    end else if (state_q == DBC_IDLE) begin
      state_q <= DBC_WAIT;
      left_q  <= cnt_i;
    end else if (tick_i) begin
      if (left_q <= CNT_W'(1)) begin
        level_q <= raw_i;
        state_q <= DBC_IDLE;
      end else begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic [NPINS-1:0]   pad_sync,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [2*NPINS-1:0] wr_data,
  output logic [NPINS-1:0]   pin_filt
);
  logic [NPINS-1:0] en_q;
  logic [CNT_W-1:0] cnt_q;

  dbc_regs #(.NPINS(NPINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_o    (en_q),
    .cnt_o   (cnt_q)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    dbc_pin_filter #(.CNT_W(CNT_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pad_sync[g]),
      .en_i   (en_q[g]),
      .cnt_i  (cnt_q),
      .tick_i (tick_ms),
      .pin_o  (pin_filt[g])
    );
  end
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker
  import dbc_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_ms,
  input logic [NPINS-1:0]   pad_sync,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [2*NPINS-1:0] wr_data,
  input logic [NPINS-1:0]   pin_filt,
  input logic [NPINS-1:0]   en_q,
  input logic [CNT_W-1:0]   cnt_q
);
  logic wr_cnt, wr_en_reg;
  assign wr_cnt    = wr_en && (wr_addr == ADDR_W'(DBC_OFS_COUNT));
  assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(DBC_OFS_ENABLE));

  // R1: configuration cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && cnt_q == '0));

  // R4 and R5: bypassed pins follow the pad
  a_r4_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ((~en_q | {NPINS{cnt_q == '0}}) & (pin_filt ^ pad_sync)) == '0);

  // R3: masked write leaves unselected enables alone
  a_r3_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> ((en_q ^ $past(en_q)) & ~$past(wr_data[2*NPINS-1:NPINS])) == '0);

  // R11: enables change only on a write to the enable offset
  a_r11_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_reg |=> $stable(en_q));

  // R11: count changes only on a write to the count offset
  a_r11_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> $stable(cnt_q));

  // R6: filtered outputs move only after a tick
  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_ms) && cnt_q != '0 && $past(cnt_q) != '0 && en_q == $past(en_q))
      |-> ((pin_filt ^ $past(pin_filt)) & en_q) == '0);
endmodule

bind port_debounce dbc_checker #(.NPINS(NPINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_ms  (tick_ms),
  .pad_sync (pad_sync),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .pin_filt (pin_filt),
  .en_q     (en_q),
  .cnt_q    (cnt_q)
);

// File: tb/test_port_debounce.sv
`timescale 1ns/1ps
module test_port_debounce;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic [7:0]  pad_sync = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  pin_filt;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  port_debounce i_port_debounce (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pad_sync(pad_sync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pin_filt(pin_filt)
  );

  // {pad value, expected output} for bypass with enables and count at 0
  localparam logic [15:0] VEC [6] = '{
    16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0101, 16'h8080
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; step(); tick_ms = 1'b0;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (pin_filt !== exp) begin
      errors++;
      $display("FAIL %s: pin_filt=%02h expected=%02h", req, pin_filt, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step();
    check("R1", 8'h00);
    rst_n = 1'b1; step();
    check("R1", 8'h00);

    // R4: table walk, everything bypassed
    for (int v = 0; v < 6; v++) begin
      pad_sync = VEC[v][15:8];
      #1 check("R4", VEC[v][7:0]);
      step();
    end
    pad_sync = 8'h00; step();

    // R2: count 3; R3: enables 0x0F then masked write -> 0x1F
    wr(4'h0, 16'h0003);
    wr(4'h4, 16'h0FFF);
    wr(4'h4, 16'h3010);
    pad_sync = 8'hFF; #1 check("R3", 8'hE0);
    step();                       // load cycle
    tick(2); check("R6", 8'hE0);
    tick(1); check("R6", 8'hFF);

    // R7: bounce restarts the count
    pad_sync = 8'hFE; step(); tick(2);
    pad_sync = 8'hFF; step();
    pad_sync = 8'hFE; step(); tick(2);
    check("R7", 8'hFF);
    tick(1); check("R7", 8'hFE);

    // R8: count rewritten mid-count
    pad_sync = 8'hFC; step(); tick(1);
    wr(4'h0, 16'h0001);
    tick(1); check("R8", 8'hFE);
    tick(1); check("R8", 8'hFC);
    pad_sync = 8'hF8; step(); tick(1);
    check("R8", 8'hF8);

    // R5: count 0 bypasses enabled pins
    wr(4'h0, 16'h0000);
    pad_sync = 8'h00; #1 check("R5", 8'h00);
    step();

    // R9: independent counters, count 2
    wr(4'h0, 16'h0002);
    pad_sync = 8'h01; step(); tick(1);
    pad_sync = 8'h03; step(); tick(1);
    check("R9", 8'h01);
    tick(1); check("R9", 8'h03);

    // R10: maximum count
    wr(4'h0, 16'h00FF);
    pad_sync = 8'h0B; step(); tick(254);
    check("R10", 8'h03);
    tick(1); check("R10", 8'h0B);

    // R11: write to unused offset changes nothing
    wr(4'h8, 16'hFF00);
    pad_sync = 8'h03; #1 check("R11", 8'h0B);
    step(); tick(254);
    check("R11", 8'h0B);
    tick(1); check("R11", 8'h03);

    // R1: reset mid-operation clears configuration
    pad_sync = 8'h0F; step();
    rst_n = 1'b0; pad_sync = 8'h00; step();
    rst_n = 1'b1; step();
    pad_sync = 8'h81; #1 check("R1", 8'h81);
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule